// File: doc/BRIEF.md
# Buffered Timekeeping Register Window

This block is the register space of a battery-backed style clock calendar, seen through a byte-wide transaction port. A host transaction begins with a start strobe that carries an address. After that each acknowledged write byte, and each byte the host takes as read, moves an internal byte pointer forward by one. The space has 2**ADDR_W bytes. The lowest seven hold packed-BCD time and calendar values. The next byte is an output control register, and all bytes above it are plain scratch storage.

The time bytes are read from a set of holding copies, not from the live counters. Every start strobe loads those copies from the counters, so a burst read returns one consistent instant while the counters keep running. A written time byte goes into the live counter on the cycle of its acknowledge. Writing the seconds byte also restarts the sub-second prescaler, and the next one-second step then follows a full prescaler period later. Bit 7 of the seconds byte is a stop bit: while it is set the prescaler holds and the counters stay frozen.

Top module: `rtcw_window`

## Requirements
- R1: After reset, bytes 00h–07h read 80h, 00h, 00h, 01h, 01h, 01h, 00h, 00h in that order. The clock is stopped, and sq_pin, sqw_en and sqw_rate are all 0.
- R2: A start strobe loads the pointer from xfer_addr. Each wr_ack or rd_ack cycle without a start advances the pointer by one, wrapping from the top address to 00h. A start strobe takes priority, so an ack in the same cycle is ignored and writes nothing.
- R3: At a start strobe the holding copies of bytes 00h–06h take the live counter values. Until the next start, reads of those bytes return the held value even after the live counters have moved on.
- R4: A write acknowledged at byte 00h–06h goes into the live counter and its holding copy in the same cycle, with unused bits forced to 0. The kept-bit masks are 00h:FF, 01h:7F, 02h:7F, 03h:07, 04h:3F, 05h:1F, 06h:FF.
- R5: While bit 7 of byte 00h is 1, no counter advances.
- R6: A write to byte 00h restarts the prescaler. The seconds value first changes CYCLES_PER_SEC cycles after the write's clock edge.
- R7: Seconds and minutes count in BCD from 00 to 59. A wrap of seconds advances minutes, and a wrap of minutes advances hours.
- R8: With bit 6 of byte 02h clear, hours count 00–23, and 23→00 advances the weekday and the date.
- R9: With bit 6 of byte 02h set, bits 4:0 hold hours 01–12 and bit 5 is the afternoon flag. 11→12 toggles the flag, 12→01 keeps it, and 11 with the flag set → 12 with the flag clear advances the weekday and the date.
- R10: Weekday counts 1–7. The date wraps to 01 after 28, 29, 30 or 31 according to the month, with February reaching 29 when the BCD year is a multiple of 4. Month 12→01 advances the year, and year 99→00.
- R11: Byte 07h keeps only bits 7, 4, 1 and 0, and the other bits read 0. sqw_en shows bit 4 and sqw_rate shows bits 1:0.
- R12: sq_pin equals bit 7 of byte 07h when bit 4 is 0, and follows wave_in when bit 4 is 1.
- R13: Bytes 08h and up are read/write storage that a start strobe does not change and that has no effect on the time bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xfer_start | input | 1 | Transaction start strobe; loads the pointer and the holding copies |
| xfer_addr | input | ADDR_W | Pointer value taken at a start strobe |
| wr_ack | input | 1 | Write acknowledge; stores wr_data at the pointer |
| wr_data | input | 8 | Byte to be written |
| rd_ack | input | 1 | Read acknowledge; the host has taken rd_data |
| rd_data | output | 8 | Byte at the current pointer |
| wave_in | input | 1 | Square wave from the separate generator |
| sq_pin | output | 1 | Output pin level |
| sqw_en | output | 1 | Square-wave enable bit from byte 07h |
| sqw_rate | output | 2 | Rate select bits from byte 07h |

## Verification
The checker watches, on every cycle, the pointer stepping and wrap, the start strobe loading the pointer, the holding copies staying unchanged between starts, frozen counters while stopped, the prescaler clearing on a seconds write, the zero bits of the control byte and the static pin level. The bench scenarios cover what needs a known history. These are the counter carry chains (12- and 24-hour rollovers, month lengths, leap February, year wrap), the exact cycle of the first step after a seconds write, a read held across several live seconds, the ack ignored during a start, and the scratch bytes keeping their data across starts.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
   typedef logic [7:0] byte_t;

   localparam int unsigned NUM_TIME  = 7;
   localparam int unsigned CTRL_IDX  = 7;
   localparam int unsigned FIRST_RAM = 8;
   localparam byte_t       CTRL_KEEP = 8'h93;

   typedef logic [NUM_TIME-1:0][7:0] tk_vec_t;

   // year, month, date, weekday, hours, minutes, seconds (stop bit set)
   localparam tk_vec_t TIME_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80};

   function automatic byte_t time_mask(input int unsigned idx);
      case (idx)
         0:       return 8'hFF;
         1:       return 8'h7F;
         2:       return 8'h7F;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic byte_t bcd_inc(input byte_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic byte_t bcd_wrap(input byte_t v, input byte_t top, input byte_t first);
      if (v == top) return first;
      return bcd_inc(v);
   endfunction

   function automatic logic leap_year(input byte_t yr);
      if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
      return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
   endfunction

   function automatic byte_t month_end(input byte_t mo, input byte_t yr);
      case (mo)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtcw_divider.sv
module rtcw_divider #(
   parameter int unsigned CYCLES_PER_SEC = 32768,
   localparam int unsigned CNT_W = $clog2(CYCLES_PER_SEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_SEC - 1);
   localparam bit IS_POW2 = (CYCLES_PER_SEC & (CYCLES_PER_SEC - 1)) == 0;

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);
   assign tick_o  = run_i && !restart_i && at_last;
   assign cnt_o   = cnt_q;

   generate
      if (IS_POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (restart_i) cnt_q <= '0;
            else if (run_i)     cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_modulo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (restart_i) cnt_q <= '0;
            else if (run_i)     cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rtcw_timekeeper.sv
module rtcw_timekeeper
   import rtcw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick_i,
   input  logic    wr_en_i,
   input  logic [2:0] wr_idx_i,
   input  byte_t   wr_data_i,
   output tk_vec_t time_o
);
   tk_vec_t time_q, nxt;
   byte_t   tmp, hr, last_day;
   logic    c_sec, c_min, c_hr, c_date, c_mon, pm;

   always_comb begin
      nxt      = time_q;
      c_sec    = 1'b0;
      c_min    = 1'b0;
      c_hr     = 1'b0;
      c_date   = 1'b0;
      c_mon    = 1'b0;
      pm       = time_q[2][5];
      hr       = 8'h00;
      tmp      = 8'h00;
      last_day = month_end(time_q[5], time_q[6]);
      if (tick_i) begin
         tmp    = {1'b0, time_q[0][6:0]};
         c_sec  = (tmp == 8'h59);
         nxt[0] = {time_q[0][7], 7'b0} | bcd_wrap(tmp, 8'h59, 8'h00);
         if (c_sec) begin
            c_min  = (time_q[1] == 8'h59);
            nxt[1] = bcd_wrap(time_q[1], 8'h59, 8'h00);
         end
         if (c_min) begin
            if (time_q[2][6]) begin
               hr = {3'b000, time_q[2][4:0]};
               if (hr == 8'h11) begin
                  hr   = 8'h12;
                  c_hr = pm;
                  pm   = !pm;
               end else begin
                  hr = bcd_wrap(hr, 8'h12, 8'h01);
               end
               nxt[2] = 8'h40 | (pm ? 8'h20 : 8'h00) | hr;
            end else begin
               hr     = {2'b00, time_q[2][5:0]};
               c_hr   = (hr == 8'h23);
               nxt[2] = bcd_wrap(hr, 8'h23, 8'h00);
            end
         end
         if (c_hr) begin
            nxt[3] = bcd_wrap(time_q[3], 8'h07, 8'h01);
            c_date = (time_q[4] == last_day);
            nxt[4] = bcd_wrap(time_q[4], last_day, 8'h01);
         end
         if (c_date) begin
            c_mon  = (time_q[5] == 8'h12);
            nxt[5] = bcd_wrap(time_q[5], 8'h12, 8'h01);
         end
         if (c_mon) nxt[6] = bcd_wrap(time_q[6], 8'h99, 8'h00);
      end
      if (wr_en_i) nxt[wr_idx_i] = wr_data_i & time_mask(int'(wr_idx_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= TIME_RESET;
      else        time_q <= nxt;
   end

   assign time_o = time_q;
endmodule

// File: rtl/rtcw_regbank.sv
module rtcw_regbank
   import rtcw_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              wr_ack_i,
   input  byte_t             wr_data_i,
   input  logic              rd_ack_i,
   input  tk_vec_t           live_i,
   output logic [ADDR_W-1:0] ptr_o,
   output tk_vec_t           snap_o,
   output byte_t             ctrl_o,
   output byte_t             rd_data_o,
   output logic              time_wr_o,
   output logic [2:0]        time_idx_o
);
   localparam int unsigned RAM_BYTES = (1 << ADDR_W) - FIRST_RAM;

   logic [ADDR_W-1:0] ptr_q, ram_idx;
   byte_t             snap_q [NUM_TIME];
   byte_t             ram_q  [RAM_BYTES];
   byte_t             ctrl_q;
   logic              wr_go, rd_go, ptr_is_time, ptr_is_ctrl;

   assign wr_go       = wr_ack_i && !start_i;
   assign rd_go       = rd_ack_i && !start_i;
   assign ptr_is_time = ptr_q < ADDR_W'(NUM_TIME);
   assign ptr_is_ctrl = ptr_q == ADDR_W'(CTRL_IDX);
   assign ram_idx     = ptr_q - ADDR_W'(FIRST_RAM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ptr_q <= '0;
      else if (start_i)        ptr_q <= start_addr_i;
      else if (wr_go || rd_go) ptr_q <= ptr_q + 1'b1;
   end

   generate
      for (genvar i = 0; i < NUM_TIME; i++) begin : g_snap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        snap_q[i] <= TIME_RESET[i];
            else if (start_i)  snap_q[i] <= live_i[i];
            else if (wr_go && ptr_q == ADDR_W'(i))
                               snap_q[i] <= wr_data_i & time_mask(i);
         end
         assign snap_o[i] = snap_q[i];
      end
      for (genvar j = 0; j < RAM_BYTES; j++) begin : g_ram
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ram_q[j] <= 8'h00;
            else if (wr_go && ptr_q == ADDR_W'(j + FIRST_RAM))
                        ram_q[j] <= wr_data_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ctrl_q <= 8'h00;
      else if (wr_go && ptr_is_ctrl)  ctrl_q <= wr_data_i & CTRL_KEEP;
   end

   always_comb begin
      if (ptr_is_time)      rd_data_o = snap_q[ptr_q[2:0]];
      else if (ptr_is_ctrl) rd_data_o = ctrl_q;
      else                  rd_data_o = ram_q[ram_idx];
   end

   assign ptr_o      = ptr_q;
   assign ctrl_o     = ctrl_q;
   assign time_wr_o  = wr_go && ptr_is_time;
   assign time_idx_o = ptr_q[2:0];
endmodule

// File: rtl/rtcw_window.sv
module rtcw_window
   import rtcw_pkg::*;
#(
   parameter int unsigned ADDR_W         = 6,
   parameter int unsigned CYCLES_PER_SEC = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic              wr_ack,
   input  logic [7:0]        wr_data,
   input  logic              rd_ack,
   output logic [7:0]        rd_data,
   input  logic              wave_in,
   output logic              sq_pin,
   output logic              sqw_en,
   output logic [1:0]        sqw_rate
);
   localparam int unsigned CNT_W = $clog2(CYCLES_PER_SEC);

   generate
      if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
         $error("rtcw_window: ADDR_W must lie in 4..8");
      end
      if (CYCLES_PER_SEC < 2) begin : g_bad_div
         $error("rtcw_window: CYCLES_PER_SEC must be at least 2");
      end
   endgenerate

   tk_vec_t           live, snap;
   byte_t             ctrl;
   logic [ADDR_W-1:0] ptr;
   logic [CNT_W-1:0]  div_cnt;
   logic [2:0]        time_idx;
   logic              time_wr, tick, halted, restart;

   assign halted  = live[0][7];
   assign restart = time_wr && (time_idx == 3'd0);

   rtcw_divider #(.CYCLES_PER_SEC(CYCLES_PER_SEC)) u_div (
      .clk(clk), .rst_n(rst_n), .run_i(!halted), .restart_i(restart),
      .tick_o(tick), .cnt_o(div_cnt)
   );

   rtcw_timekeeper u_tk (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(time_wr),
      .wr_idx_i(time_idx), .wr_data_i(wr_data), .time_o(live)
   );

   rtcw_regbank #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .start_i(xfer_start), .start_addr_i(xfer_addr),
      .wr_ack_i(wr_ack), .wr_data_i(wr_data), .rd_ack_i(rd_ack), .live_i(live),
      .ptr_o(ptr), .snap_o(snap), .ctrl_o(ctrl), .rd_data_o(rd_data),
      .time_wr_o(time_wr), .time_idx_o(time_idx)
   );

   assign sqw_en   = ctrl[4];
   assign sqw_rate = ctrl[1:0];
   assign sq_pin   = ctrl[4] ? wave_in : ctrl[7];
endmodule

// File: rtl/rtcw_window_chk.sv
module rtcw_window_chk
   import rtcw_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CNT_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_start,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic              wr_ack,
   input logic              rd_ack,
   input logic [ADDR_W-1:0] ptr,
   input logic              time_wr,
   input logic              halted,
   input logic [CNT_W-1:0]  div_cnt,
   input tk_vec_t           live,
   input tk_vec_t           snap,
   input logic [7:0]        rd_data,
   input logic [7:0]        ctrl,
   input logic              sq_pin
);
   p_start_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> ptr == $past(xfer_addr));

   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_start && (wr_ack || rd_ack)) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

   p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_start && !time_wr) |=> $stable(snap));

   p_halt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !time_wr) |=> $stable(live));

   p_div_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (time_wr && ptr == '0) |=> div_cnt == '0);

   p_ctrl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == ADDR_W'(CTRL_IDX)) |-> (rd_data[6:5] == 2'b00 && rd_data[3:2] == 2'b00));

   p_static_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[4] |-> sq_pin == ctrl[7]);
endmodule

bind rtcw_window rtcw_window_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
   .wr_ack(wr_ack), .rd_ack(rd_ack), .ptr(ptr), .time_wr(time_wr),
   .halted(halted), .div_cnt(div_cnt), .live(live), .snap(snap),
   .rd_data(rd_data), .ctrl(ctrl), .sq_pin(sq_pin)
);

// File: tb/rtcw_window_bench.sv
module rtcw_window_bench;
   localparam int unsigned CPS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_start = 1'b0;
   logic [5:0] xfer_addr = '0;
   logic       wr_ack = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data;
   logic       wave_in = 1'b0;
   logic       sq_pin, sqw_en;
   logic [1:0] sqw_rate;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   rtcw_window #(.ADDR_W(6), .CYCLES_PER_SEC(CPS)) u_rtcw_window (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
      .wr_ack(wr_ack), .wr_data(wr_data), .rd_ack(rd_ack), .rd_data(rd_data),
      .wave_in(wave_in), .sq_pin(sq_pin), .sqw_en(sqw_en), .sqw_rate(sqw_rate)
   );

   task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: compares each accepted read against the scoreboard queue
   initial forever begin
      @(negedge clk);
      #1;
      if (rd_ack && !xfer_start) begin
         if (exp_q.size() == 0) check_val("unexpected read", rd_data, 8'hxx);
         else check_val(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic begin_xfer(input logic [5:0] a);
      xfer_start = 1'b1; xfer_addr = a;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic put(input logic [7:0] d);
      wr_ack = 1'b1; wr_data = d;
      @(negedge clk);
      wr_ack = 1'b0;
   endtask

   task automatic get(input logic [7:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic roll(input logic [7:0] w [7], input logic [7:0] e [7], input string tag);
      begin_xfer(6'h00);
      for (int i = 0; i < 7; i++) put(w[i]);
      idle(12);
      begin_xfer(6'h00);
      for (int i = 0; i < 7; i++) get(e[i], tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check_val("R1 sq_pin", {7'b0, sq_pin}, 8'h00);
      check_val("R1 sqw_en/rate", {5'b0, sqw_en, sqw_rate}, 8'h00);
      begin_xfer(6'h00);
      get(8'h80, "R1"); get(8'h00, "R1"); get(8'h00, "R1"); get(8'h01, "R1");
      get(8'h01, "R1"); get(8'h01, "R1"); get(8'h00, "R1"); get(8'h00, "R1");
      // R5 stopped after reset
      idle(60);
      begin_xfer(6'h00); get(8'h80, "R5");
      // R13 scratch storage, R2 wrap
      begin_xfer(6'h08); put(8'h11); put(8'h22);
      begin_xfer(6'h3E); put(8'h5A); put(8'hC3); get(8'h80, "R2 wrap after write");
      begin_xfer(6'h08); get(8'h11, "R13"); get(8'h22, "R13");
      begin_xfer(6'h3E); get(8'h5A, "R13"); get(8'hC3, "R13"); get(8'h80, "R2 wrap after read");
      begin_xfer(6'h00); get(8'h80, "R13 time untouched");
      // R2 ack ignored during a start
      xfer_start = 1'b1; xfer_addr = 6'h08; wr_ack = 1'b1; wr_data = 8'hEE;
      @(negedge clk);
      xfer_start = 1'b0; wr_ack = 1'b0;
      get(8'h11, "R2 write ignored at start");
      xfer_start = 1'b1; xfer_addr = 6'h09; rd_ack = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0; rd_ack = 1'b0;
      get(8'h22, "R2 read ignored at start");
      // R4 masks while stopped
      begin_xfer(6'h01);
      for (int i = 0; i < 6; i++) put(8'hFF);
      begin_xfer(6'h01);
      get(8'h7F, "R4"); get(8'h7F, "R4"); get(8'h07, "R4");
      get(8'h3F, "R4"); get(8'h1F, "R4"); get(8'hFF, "R4");
      // R11 control byte, R12 pin
      begin_xfer(6'h07); put(8'hFF);
      begin_xfer(6'h07); get(8'h93, "R11");
      check_val("R11 sqw_en/rate", {5'b0, sqw_en, sqw_rate}, 8'h07);
      wave_in = 1'b1; #1;
      check_val("R12 follow wave high", {7'b0, sq_pin}, 8'h01);
      wave_in = 1'b0; #1;
      check_val("R12 follow wave low", {7'b0, sq_pin}, 8'h00);
      @(negedge clk);
      begin_xfer(6'h07); put(8'h80);
      wave_in = 1'b0; #1;
      check_val("R12 static high", {7'b0, sq_pin}, 8'h01);
      @(negedge clk);
      begin_xfer(6'h07); put(8'h00);
      wave_in = 1'b1; #1;
      check_val("R12 static low", {7'b0, sq_pin}, 8'h00);
      @(negedge clk);
      // R6 prescaler restart timing
      begin_xfer(6'h00); put(8'h00);
      idle(14);
      begin_xfer(6'h00); get(8'h00, "R6 last cycle before step");
      begin_xfer(6'h00); get(8'h01, "R6 first step");
      // R3 held copy while live runs
      begin_xfer(6'h00); put(8'h10);
      begin_xfer(6'h00);
      idle(50);
      get(8'h10, "R3 held");
      begin_xfer(6'h00); get(8'h13, "R3 refreshed");
      // R5 stop bit set by a write
      begin_xfer(6'h00); put(8'hB0);
      idle(40);
      begin_xfer(6'h00); get(8'hB0, "R5 stopped by write");
      // carry chains
      roll('{8'h59, 8'h09, 8'h10, 8'h04, 8'h10, 8'h10, 8'h10},
           '{8'h00, 8'h10, 8'h10, 8'h04, 8'h10, 8'h10, 8'h10}, "R7 minute carry");
      roll('{8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23},
           '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23}, "R8/R10 midnight Feb28");
      roll('{8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24},
           '{8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24}, "R10 leap");
      roll('{8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h15},
           '{8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h15}, "R10 short month");
      roll('{8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99},
           '{8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00}, "R10 year wrap");
      roll('{8'h59, 8'h59, 8'h71, 8'h01, 8'h15, 8'h06, 8'h20},
           '{8'h00, 8'h00, 8'h52, 8'h02, 8'h16, 8'h06, 8'h20}, "R9 11PM to 12AM");
      roll('{8'h59, 8'h59, 8'h51, 8'h01, 8'h15, 8'h06, 8'h20},
           '{8'h00, 8'h00, 8'h72, 8'h01, 8'h15, 8'h06, 8'h20}, "R9 11AM to 12PM");
      roll('{8'h59, 8'h59, 8'h72, 8'h01, 8'h15, 8'h06, 8'h20},
           '{8'h00, 8'h00, 8'h61, 8'h01, 8'h15, 8'h06, 8'h20}, "R9 12 to 01");
      begin_xfer(6'h08); get(8'h11, "R13 kept across starts");
      idle(3);
      if (exp_q.size() != 0) check_val("scoreboard drained", 8'(exp_q.size()), 8'h00);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule